// File: doc/BRIEF.md
# Fixed-Priority Slave-Port Arbiter for a Multi-Master Crossbar

This block sits on one slave port of a multi-master crossbar built on AHB-Lite-style buses. Each master port gives it a transfer type, an address, a control word and a select line. The select line says whether the master's current address decodes to this slave. A master is counted as requesting when its select is high and its transfer type is NONSEQ or SEQ. The arbiter picks one owner by fixed priority, with the lowest index winning, and forwards that owner's address phase to the slave. It returns a ready signal to every master, which holds back any requester that has not been granted.

Ownership moves only on a cycle where the slave reports ready, so an address phase is never split. There are three ways ownership changes hands:
- **Preemption.** A higher-priority requester takes the port from a lower-priority owner that is still requesting. The handover leaves no gap on the slave bus.
- **Release after a wait-stated transfer.** An owner lets go by issuing IDLE or by moving its transfer to another slave, and its last data phase had wait states. The next requester's address goes out directly.
- **Release after a zero-wait transfer.** The same release, but the last data phase completed with no wait states. This costs exactly one IDLE cycle.

With nobody requesting, the arbiter itself parks on the port and drives IDLE. Two encoded outputs report the current owner and the owner of the data phase now in progress. The data-phase owner is what steers the data multiplexers.

Top module: `xbar_port_arbiter`

## Requirements
- R1: While reset is high, and after it falls with no requests, `owner_o` and `dphase_o` both hold the parking code NM (4 with defaults).
- R2: With no master requesting (request means `m_req[i]` high and `m_htrans[2i+1]` high, i.e. type 2'b10 NONSEQ or 2'b11 SEQ; 2'b00 is IDLE), `s_htrans` is 2'b00, and after a ready cycle `owner_o` returns to NM.
- R3: While parked, a requesting master's type, address and control appear on the slave bus in the same cycle, and its ready follows `s_hready`.
- R4: Among simultaneous requesters the lowest index is forwarded; at most one requesting master sees its ready high.
- R5: When a higher-priority master requests while a lower-priority owner is still requesting, the owner's pending address is accepted on that ready cycle and the higher master's address follows in the next cycle with no IDLE between.
- R6: `owner_o` does not change on a cycle with `s_hready` low; a wait-stated owner completes its pending transfer before a higher-priority master takes over.
- R7: When the owner releases the port and its last data phase had no wait state, the slave bus shows exactly one IDLE cycle before the next requester's address.
- R8: When the owner releases during a data phase that has had a wait state, the next requester's address is presented while the wait continues and is accepted when the slave becomes ready, with no IDLE.
- R9: A requesting master that is not forwarded sees ready 0; the forwarded master sees `s_hready`; a non-requesting master sees `s_hready` if it owns the data phase and 1 otherwise.
- R10: On each ready cycle `dphase_o` takes the index of the forwarded master, or NM if the slave bus carried IDLE.
- R11: An owner whose select drops while its type stays NONSEQ (a transfer to another slave) releases the port exactly as an IDLE would.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| m_req | input | NM | Per-master select: the address decodes to this slave |
| m_htrans | input | 2*NM | Per-master transfer type, two bits per master |
| m_haddr | input | NM*AW | Per-master address |
| m_hctrl | input | NM*CW | Per-master control word (direction, size and the like) |
| m_hready | output | NM | Per-master ready |
| s_hready | input | 1 | Slave ready, which ends the data phase |
| s_htrans | output | 2 | Transfer type to the slave |
| s_haddr | output | AW | Address to the slave |
| s_hctrl | output | CW | Control word to the slave |
| owner_o | output | $clog2(NM+1) | Current owner, NM when parked |
| dphase_o | output | $clog2(NM+1) | Owner of the data phase in progress, NM after IDLE |

## Verification
The bench builds the arbiter with four masters, a 16-bit address and a 4-bit control word. With four masters every priority relation can be reached: top over bottom, middle over middle, and a lone lowest-priority requester taking the parked port. The owner code then needs three bits, so the parking code 4 cannot be confused with any master index. The table drives preemption with and without wait states, both release timings, and both release styles with the slave ready held low for one or two cycles.

// File: rtl/xpa_pkg.sv
package xpa_pkg;
  typedef enum logic [1:0] {
    HT_IDLE   = 2'b00,
    HT_BUSY   = 2'b01,
    HT_NONSEQ = 2'b10,
    HT_SEQ    = 2'b11
  } htrans_e;

  // A transfer type asks for the slave when its upper bit is set.
  function automatic logic trans_active(input logic [1:0] t);
    return t[1];
  endfunction
endpackage

// File: rtl/xpa_prio_pick.sv
module xpa_prio_pick #(
  parameter int NM = 4,
  parameter int OW = $clog2(NM + 1)
) (
  input  logic [NM-1:0] valid,
  output logic          any,
  output logic [OW-1:0] idx
);
  always_comb begin
    any = |valid;
    idx = OW'(NM);
    for (int i = NM - 1; i >= 0; i--) begin
      if (valid[i]) idx = OW'(i);
    end
  end
endmodule

// File: rtl/xpa_addr_mux.sv
module xpa_addr_mux #(
  parameter int NM = 4,
  parameter int AW = 16,
  parameter int CW = 4,
  parameter int OW = $clog2(NM + 1)
) (
  input  logic             sel_ok,
  input  logic [OW-1:0]    sel,
  input  logic [2*NM-1:0]  m_htrans,
  input  logic [NM*AW-1:0] m_haddr,
  input  logic [NM*CW-1:0] m_hctrl,
  output logic [1:0]       s_htrans,
  output logic [AW-1:0]    s_haddr,
  output logic [CW-1:0]    s_hctrl
);
  import xpa_pkg::*;

  logic [NM-1:0] hit;

  genvar g;
  generate
    for (g = 0; g < NM; g++) begin : g_hit
      assign hit[g] = sel_ok && (sel == OW'(g));
    end
  endgenerate

  // AND-OR selection; all zero (IDLE) when no master is forwarded.
  always_comb begin
    s_htrans = HT_IDLE;
    s_haddr  = '0;
    s_hctrl  = '0;
    for (int i = 0; i < NM; i++) begin
      s_htrans = s_htrans | ({2{hit[i]}}  & m_htrans[2*i +: 2]);
      s_haddr  = s_haddr  | ({AW{hit[i]}} & m_haddr[AW*i +: AW]);
      s_hctrl  = s_hctrl  | ({CW{hit[i]}} & m_hctrl[CW*i +: CW]);
    end
  end
endmodule

// File: rtl/xpa_own_ctl.sv
module xpa_own_ctl #(
  parameter int NM = 4,
  parameter int OW = $clog2(NM + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          s_hready,
  input  logic [NM-1:0] valid,
  input  logic          hp_any,
  input  logic [OW-1:0] hp_idx,
  output logic [OW-1:0] owner_q,
  output logic [OW-1:0] dph_q,
  output logic          sel_ok,
  output logic [OW-1:0] sel
);
  localparam logic [OW-1:0] PARK = OW'(NM);

  logic          own_hit;
  logic          waited_q;
  logic [OW-1:0] owner_n;

  always_comb begin
    own_hit = 1'b0;
    for (int i = 0; i < NM; i++) begin
      if (owner_q == OW'(i)) own_hit = valid[i];
    end
  end

  // Address-phase source: the owner while it keeps requesting; otherwise the
  // best requester, straight away if parked or if the outgoing data phase has
  // already stalled; otherwise an IDLE cycle.
  always_comb begin
    sel_ok = 1'b0;
    sel    = PARK;
    if (own_hit) begin
      sel_ok = 1'b1;
      sel    = owner_q;
    end else if (hp_any && (owner_q == PARK || waited_q)) begin
      sel_ok = 1'b1;
      sel    = hp_idx;
    end
  end

  always_comb begin
    if (sel_ok) owner_n = (hp_any && hp_idx < sel) ? hp_idx : sel;
    else        owner_n = hp_any ? hp_idx : PARK;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      owner_q  <= PARK;
      dph_q    <= PARK;
      waited_q <= 1'b0;
    end else begin
      waited_q <= ~s_hready;
      if (s_hready) begin
        owner_q <= owner_n;
        dph_q   <= sel_ok ? sel : PARK;
      end
    end
  end
endmodule

// File: rtl/xbar_port_arbiter.sv
module xbar_port_arbiter #(
  parameter int NM = 4,
  parameter int AW = 16,
  parameter int CW = 4,
  parameter int OW = $clog2(NM + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NM-1:0]    m_req,
  input  logic [2*NM-1:0]  m_htrans,
  input  logic [NM*AW-1:0] m_haddr,
  input  logic [NM*CW-1:0] m_hctrl,
  output logic [NM-1:0]    m_hready,
  input  logic             s_hready,
  output logic [1:0]       s_htrans,
  output logic [AW-1:0]    s_haddr,
  output logic [CW-1:0]    s_hctrl,
  output logic [OW-1:0]    owner_o,
  output logic [OW-1:0]    dphase_o
);
  import xpa_pkg::*;

  logic [NM-1:0] valid;
  logic          hp_any;
  logic [OW-1:0] hp_idx;
  logic          sel_ok;
  logic [OW-1:0] sel;
  logic [OW-1:0] owner_q;
  logic [OW-1:0] dph_q;

  genvar g;
  generate
    for (g = 0; g < NM; g++) begin : g_master
      logic granted;
      assign valid[g]    = m_req[g] & trans_active(m_htrans[2*g +: 2]);
      assign granted     = sel_ok && (sel == OW'(g));
      assign m_hready[g] = valid[g] ? (granted & s_hready)
                                    : ((dph_q == OW'(g)) ? s_hready : 1'b1);
    end
  endgenerate

  xpa_prio_pick #(.NM(NM), .OW(OW)) u_pick (
    .valid (valid),
    .any   (hp_any),
    .idx   (hp_idx)
  );

  xpa_own_ctl #(.NM(NM), .OW(OW)) u_ctl (
    .clk      (clk),
    .rst      (rst),
    .s_hready (s_hready),
    .valid    (valid),
    .hp_any   (hp_any),
    .hp_idx   (hp_idx),
    .owner_q  (owner_q),
    .dph_q    (dph_q),
    .sel_ok   (sel_ok),
    .sel      (sel)
  );

  xpa_addr_mux #(.NM(NM), .AW(AW), .CW(CW), .OW(OW)) u_mux (
    .sel_ok   (sel_ok),
    .sel      (sel),
    .m_htrans (m_htrans),
    .m_haddr  (m_haddr),
    .m_hctrl  (m_hctrl),
    .s_htrans (s_htrans),
    .s_haddr  (s_haddr),
    .s_hctrl  (s_hctrl)
  );

  assign owner_o  = owner_q;
  assign dphase_o = dph_q;
endmodule

// File: rtl/xbar_port_arbiter_chk.sv
module xbar_port_arbiter_chk #(
  parameter int NM = 4,
  parameter int AW = 16,
  parameter int OW = $clog2(NM + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic [NM-1:0]    m_req,
  input logic [2*NM-1:0]  m_htrans,
  input logic [NM*AW-1:0] m_haddr,
  input logic [NM-1:0]    m_hready,
  input logic             s_hready,
  input logic [1:0]       s_htrans,
  input logic [AW-1:0]    s_haddr,
  input logic [OW-1:0]    owner_o,
  input logic [OW-1:0]    dphase_o
);
  localparam logic [OW-1:0] PARK = OW'(NM);

  logic [NM-1:0] asks;

  genvar g;
  generate
    for (g = 0; g < NM; g++) begin : g_chk
      assign asks[g] = m_req[g] & m_htrans[2*g+1];

      assert_grant_path_R9: assert property (@(posedge clk) disable iff (rst)
        (asks[g] && m_hready[g]) |-> (s_htrans[1] && s_haddr == m_haddr[AW*g +: AW]));
    end
  endgenerate

  assert_reset_park_R1: assert property (@(posedge clk)
    rst |=> (owner_o == PARK && dphase_o == PARK));

  assert_idle_park_R2: assert property (@(posedge clk) disable iff (rst)
    (asks == '0) |-> (s_htrans == 2'b00));

  assert_single_grant_R4: assert property (@(posedge clk) disable iff (rst)
    $countones(asks & m_hready) <= 1);

  assert_hold_owner_R6: assert property (@(posedge clk) disable iff (rst)
    !s_hready |=> $stable(owner_o));

  assert_dphase_idle_R10: assert property (@(posedge clk) disable iff (rst)
    (s_hready && !s_htrans[1]) |=> (dphase_o == PARK));
endmodule

bind xbar_port_arbiter xbar_port_arbiter_chk #(.NM(NM), .AW(AW), .OW(OW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .m_req    (m_req),
  .m_htrans (m_htrans),
  .m_haddr  (m_haddr),
  .m_hready (m_hready),
  .s_hready (s_hready),
  .s_htrans (s_htrans),
  .s_haddr  (s_haddr),
  .owner_o  (owner_o),
  .dphase_o (dphase_o)
);

// File: tb/xbar_port_arbiter_test.sv
module xbar_port_arbiter_test;
  localparam int CLK_PERIOD = 10;
  localparam int NM = 4;
  localparam int AW = 16;
  localparam int CW = 4;
  localparam int OW = 3;
  localparam int NV = 18;

  // Row: {requesters, s_hready, exp active, exp source, exp owner, exp ready}
  localparam logic [14:0] TBL [NV] = '{
    {4'b0000, 1'b1, 1'b0, 2'd0, 3'd4, 4'b1111},  // R2 parked idle
    {4'b0100, 1'b1, 1'b1, 2'd2, 3'd4, 4'b1111},  // R3 forwarded while parked
    {4'b0100, 1'b1, 1'b1, 2'd2, 3'd2, 4'b1111},
    {4'b0101, 1'b1, 1'b1, 2'd2, 3'd2, 4'b1110},  // R5 owner's last transfer
    {4'b0101, 1'b1, 1'b1, 2'd0, 3'd0, 4'b1011},  // R5 no gap
    {4'b0100, 1'b1, 1'b0, 2'd0, 3'd0, 4'b1011},  // R7 forced IDLE
    {4'b0100, 1'b1, 1'b1, 2'd2, 3'd2, 4'b1111},  // R7 only one
    {4'b0110, 1'b0, 1'b1, 2'd2, 3'd2, 4'b1001},  // R6 wait state
    {4'b0110, 1'b0, 1'b1, 2'd2, 3'd2, 4'b1001},  // R6 held
    {4'b0110, 1'b1, 1'b1, 2'd2, 3'd2, 4'b1101},  // R6 one more transfer
    {4'b0110, 1'b1, 1'b1, 2'd1, 3'd1, 4'b1011},  // R9 stalled master 2
    {4'b0100, 1'b0, 1'b0, 2'd0, 3'd1, 4'b1001},  // R8 release during wait
    {4'b0100, 1'b1, 1'b1, 2'd2, 3'd1, 4'b1111},  // R8 seamless
    {4'b0000, 1'b1, 1'b0, 2'd0, 3'd2, 4'b1111},  // R2
    {4'b0000, 1'b1, 1'b0, 2'd0, 3'd4, 4'b1111},  // R2 back to parking
    {4'b1000, 1'b0, 1'b1, 2'd3, 3'd4, 4'b0111},  // R3 lowest priority
    {4'b1000, 1'b1, 1'b1, 2'd3, 3'd4, 4'b1111},
    {4'b1000, 1'b1, 1'b1, 2'd3, 3'd3, 4'b1111}
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [NM-1:0]    m_req = '0;
  logic [2*NM-1:0]  m_htrans = '0;
  logic [NM*AW-1:0] m_haddr;
  logic [NM*CW-1:0] m_hctrl;
  logic [NM-1:0]    m_hready;
  logic             s_hready = 1'b1;
  logic [1:0]       s_htrans;
  logic [AW-1:0]    s_haddr;
  logic [CW-1:0]    s_hctrl;
  logic [OW-1:0]    owner_o;
  logic [OW-1:0]    dphase_o;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  xbar_port_arbiter #(.NM(NM), .AW(AW), .CW(CW), .OW(OW)) uut (
    .clk(clk), .rst(rst), .m_req(m_req), .m_htrans(m_htrans),
    .m_haddr(m_haddr), .m_hctrl(m_hctrl), .m_hready(m_hready),
    .s_hready(s_hready), .s_htrans(s_htrans), .s_haddr(s_haddr),
    .s_hctrl(s_hctrl), .owner_o(owner_o), .dphase_o(dphase_o)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Drive at a falling edge; settle 1 time unit before sampling.
  task automatic drive(input logic [3:0] rq, input logic [3:0] tv, input logic rdy);
    @(negedge clk);
    m_req    = rq;
    s_hready = rdy;
    for (int i = 0; i < NM; i++) m_htrans[2*i +: 2] = tv[i] ? 2'b10 : 2'b00;
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual %0d expected below 20000 cycles", cycles);
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < NM; i++) begin
      m_haddr[AW*i +: AW] = AW'(16'hA000 + i);
      m_hctrl[CW*i +: CW] = CW'(i + 5);
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R1 owner after reset", 32'(owner_o), 32'd4);
    chk("R1 dphase after reset", 32'(dphase_o), 32'd4);
    chk("R1 slave idle after reset", 32'(s_htrans), 32'd0);

    for (int v = 0; v < NV; v++) begin
      logic [14:0] row;
      row = TBL[v];
      drive(row[14:11], row[14:11], row[10]);
      chk($sformatf("R3 R5 R7 R8 row %0d active", v), 32'(s_htrans[1]), 32'(row[9]));
      if (row[9]) begin
        chk($sformatf("R4 row %0d address", v), 32'(s_haddr), 32'hA000 + 32'(row[8:7]));
        chk($sformatf("R3 row %0d control", v), 32'(s_hctrl), 32'(row[8:7]) + 32'd5);
      end
      chk($sformatf("R6 row %0d owner", v), 32'(owner_o), 32'(row[6:4]));
      chk($sformatf("R9 row %0d ready", v), 32'(m_hready), 32'(row[3:0]));
    end

    // R11: owner 3 moves to another slave (select low, NONSEQ kept)
    drive(4'b0001, 4'b1001, 1'b1);
    chk("R11 release shows IDLE", 32'(s_htrans), 32'd0);
    chk("R11 owner before edge", 32'(owner_o), 32'd3);
    chk("R9 waiting master 0 stalled", 32'(m_hready[0]), 32'd0);
    chk("R9 releasing master 3 ready", 32'(m_hready[3]), 32'd1);
    drive(4'b0001, 4'b1001, 1'b1);
    chk("R11 new owner forwarded", 32'(s_htrans), 32'd2);
    chk("R11 new owner address", 32'(s_haddr), 32'hA000);
    chk("R11 owner is 0", 32'(owner_o), 32'd0);
    chk("R10 dphase after IDLE", 32'(dphase_o), 32'd4);
    drive(4'b0000, 4'b0000, 1'b1);
    chk("R10 dphase follows accepted master", 32'(dphase_o), 32'd0);
    chk("R2 idle with no request", 32'(s_htrans), 32'd0);

    // R1: reset while a master requests
    drive(4'b0100, 4'b0100, 1'b1);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_req = '0;
    m_htrans = '0;
    #1;
    chk("R1 owner after mid reset", 32'(owner_o), 32'd4);
    chk("R1 dphase after mid reset", 32'(dphase_o), 32'd4);

    // R4: two requesters from the parked state
    drive(4'b1010, 4'b1010, 1'b1);
    chk("R4 forwarded address", 32'(s_haddr), 32'hA001);
    chk("R4 ready pattern", 32'(m_hready), 32'b0111);
    chk("R3 owner still parked", 32'(owner_o), 32'd4);
    drive(4'b1010, 4'b1010, 1'b1);
    chk("R4 owner is master 1", 32'(owner_o), 32'd1);

    finish_run();
  end
endmodule